// File: doc/BRIEF.md
# Instruction Cache Tag Lookup with Multi-Hit Detection

This block holds the tag and valid state of a small set-associative instruction cache and answers one lookup per clock. A request carries a byte address and an operation code: a fetch lookup, a touch (prefetch) request, or an invalidate-by-address. All ways of the addressed set are compared in parallel. The registered response reports a hit and its way, a miss together with the way that the new line has been allocated into, or a multi-hit error. A multi-hit error is a parity-class machine-check condition for the core's error logic. Data storage, the memory bus and interrupt delivery belong to other blocks.

A force-miss control input lets touch requests ignore a real hit. The touch then allocates the same line again into the next victim way. Software uses this to place duplicate copies of a line on purpose, so that a later fetch of that line exercises the multi-hit error path. Fetches always do a true compare. Victims are chosen round-robin per set. An invalidate clears every way that holds the line, so it also removes duplicates.

Top module: `icl_tag_lookup`

## Requirements
- R1: During and after a synchronous active-low reset, every way is invalid and `rsp_valid` is 0. The first fetch of any line after reset misses.
- R2: A request accepted on a clock edge (`req_valid`=1) produces exactly one response, with `rsp_valid`=1, on the next edge. A cycle without a request produces `rsp_valid`=0, and then hit, miss and multi-hit are all 0. Requests may be issued back to back.
- R3: The address splits into bits [4:0] line offset (ignored), bits [8:5] set index and bits [31:9] tag. A fetch (`req_op`=2'b00) that matches no valid way sets `rsp_miss`=1, with `rsp_way` = the allocated way. The tag is written there, so the next fetch of that line hits with `rsp_hit`=1 and the same `rsp_way`. Hit and miss are never both 1.
- R4: Allocation in each set is round-robin. After reset, successive allocations in a set use ways 0, 1, 2, 3, 0, … Each set keeps its own pointer, and only an allocation advances it.
- R5: A touch (`req_op`=2'b01) with `force_miss`=0 that matches a valid way reports a hit on that way and allocates nothing.
- R6: A touch with `force_miss`=1 always reports `rsp_miss`=1 and `rsp_hit`=0, and it allocates the victim way even when the line is already present, which creates a duplicate entry.
- R7: A fetch that matches two or more valid ways sets `rsp_multi_err`=1 with `rsp_hit`=0 and `rsp_miss`=0, and it does not allocate or move the round-robin pointer. Only fetches raise `rsp_multi_err`.
- R8: `force_miss` has no effect on fetches.
- R9: An invalidate (`req_op`=2'b10) clears every valid way of the set whose tag matches and leaves the others valid. Its response has hit, miss and multi-hit all 0.
- R10: A touch with `force_miss`=0 that matches several ways reports a hit on the lowest-numbered matching way and no error.
- R11: `req_op`=2'b11 is reserved. It changes no state, and its response has all flags 0 and `rsp_way`=0. Whenever hit and miss are both 0, `rsp_way` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 fetch, 01 touch, 10 invalidate, 11 reserved |
| req_addr | input | 32 | Byte address of the line |
| force_miss | input | 1 | Touch requests ignore a real hit and allocate |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Single (fetch) or lowest (touch) matching way found |
| rsp_miss | output | 1 | Line allocated; fill must start |
| rsp_way | output | 2 | Hit way or allocated way, else 0 |
| rsp_multi_err | output | 1 | Fetch matched more than one valid way |

## Verification
The assertions assume that `req_op`, `req_valid` and `force_miss` are never unknown while reset is released, and that at most one request is presented per cycle. They also assume that `force_miss` only matters when it comes with a touch. The bench drives every input at the falling edge from known values and holds `force_miss` low whenever it issues no request. It deliberately raises `force_miss` together with fetches as well as touches, to show that fetches ignore it.

// File: rtl/icl_pkg.sv
// Package: shared operation codes for the instruction cache tag lookup.
// Assumes the request opcode is a 2-bit field driven by the fetch unit.
package icl_pkg;

    typedef enum logic [1:0] {
        OP_FETCH = 2'b00,
        OP_TOUCH = 2'b01,
        OP_INVAL = 2'b10,
        OP_RSVD  = 2'b11
    } icl_op_e;

endpackage

// File: rtl/icl_tag_store.sv
// Tag and valid storage for all sets and ways.
// Provides a combinational read of one set, one way allocation write
// and a masked invalidate of one set per cycle. Assumes allocation and
// invalidate are never requested in the same cycle.
module icl_tag_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int TAG_W = 23,
    parameter int IDX_W = 4,
    parameter int WAY_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tags,
    output logic [WAYS-1:0]             rd_valid,
    input  logic                        alloc_en,
    input  logic [IDX_W-1:0]            alloc_set,
    input  logic [WAY_W-1:0]            alloc_way,
    input  logic [TAG_W-1:0]            alloc_tag,
    input  logic                        inv_en,
    input  logic [IDX_W-1:0]            inv_set,
    input  logic [WAYS-1:0]             inv_mask
);

    logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
    logic [WAYS-1:0]            vld_q [SETS];

    genvar gs;
    generate
        for (gs = 0; gs < SETS; gs++) begin : g_set
            logic set_alloc;
            logic set_inv;
            logic [WAYS-1:0] way_sel;

            // Decode whether this set is the target of this cycle's write.
            assign set_alloc = alloc_en && (alloc_set == IDX_W'(gs));
            assign set_inv   = inv_en   && (inv_set   == IDX_W'(gs));

            // One-hot select of the way being allocated.
            always_comb begin
                way_sel = '0;
                way_sel[alloc_way] = 1'b1;
            end

            // Valid bits: cleared by reset, set on allocation, masked on invalidate.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[gs] <= '0;
                end else if (set_alloc) begin
                    vld_q[gs] <= vld_q[gs] | way_sel;
                end else if (set_inv) begin
                    vld_q[gs] <= vld_q[gs] & ~inv_mask;
                end
            end

            // Tag bits: written on allocation only, no reset needed.
            always_ff @(posedge clk) begin
                if (set_alloc) begin
                    tag_q[gs][alloc_way] <= alloc_tag;
                end
            end
        end
    endgenerate

    // Present the addressed set to the comparators.
    always_comb begin
        rd_tags  = tag_q[rd_set];
        rd_valid = vld_q[rd_set];
    end

endmodule

// File: rtl/icl_way_match.sv
// Parallel tag comparator for one set.
// Produces the per-way match vector, the number of matching ways,
// the lowest matching way, and any/multi flags. Purely combinational.
module icl_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 23,
    parameter int WAY_W = 2,
    parameter int CNT_W = 3
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0]            valid,
    input  logic [TAG_W-1:0]           look_tag,
    output logic [WAYS-1:0]            match_vec,
    output logic [CNT_W-1:0]           match_cnt,
    output logic [WAY_W-1:0]           low_way,
    output logic                       any_match,
    output logic                       multi_match
);

    genvar gw;
    generate
        for (gw = 0; gw < WAYS; gw++) begin : g_cmp
            // Compare one way; an invalid way never matches.
            assign match_vec[gw] = valid[gw] && (tags[gw] == look_tag);
        end
    endgenerate

    // Count matching ways to separate single from multiple hits.
    always_comb begin
        match_cnt = '0;
        for (int w = 0; w < WAYS; w++) begin
            match_cnt = match_cnt + CNT_W'(match_vec[w]);
        end
    end

    // Priority encode: the lowest-numbered matching way wins.
    always_comb begin
        low_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_vec[w]) begin
                low_way = WAY_W'(w);
            end
        end
    end

    assign any_match   = |match_vec;
    assign multi_match = (match_cnt > CNT_W'(1));

endmodule

// File: rtl/icl_victim_rr.sv
// Per-set round-robin victim pointer.
// Reports the next way to allocate for the addressed set and advances
// that set's pointer only when an allocation happens there.
module icl_victim_rr #(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int IDX_W = 4,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_set,
    output logic [WAY_W-1:0] victim,
    input  logic             adv_en,
    input  logic [IDX_W-1:0] adv_set
);

    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] ptr_q [SETS];

    genvar gs;
    generate
        for (gs = 0; gs < SETS; gs++) begin : g_ptr
            // Step this set's pointer after an allocation, wrapping at the last way.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ptr_q[gs] <= '0;
                end else if (adv_en && (adv_set == IDX_W'(gs))) begin
                    ptr_q[gs] <= (ptr_q[gs] == LAST_WAY) ? '0 : ptr_q[gs] + 1'b1;
                end
            end
        end
    endgenerate

    assign victim = ptr_q[rd_set];

endmodule

// File: rtl/icl_tag_lookup.sv
// Instruction cache tag lookup with multi-hit detection (top level).
// Accepts one fetch, touch or invalidate per cycle and answers on the
// next edge. force_miss makes touches allocate even on a real hit, so
// duplicates can be planted. Fetches matching several ways raise a
// multi-hit error. Assumes WAYS >= 2 and inputs are never unknown.
module icl_tag_lookup #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int WAYS   = 4,
    parameter int SETS   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [1:0]                req_op,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic                      force_miss,
    output logic                      rsp_valid,
    output logic                      rsp_hit,
    output logic                      rsp_miss,
    output logic [$clog2(WAYS)-1:0]   rsp_way,
    output logic                      rsp_multi_err
);

    import icl_pkg::*;

    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int CNT_W = $clog2(WAYS + 1);

    icl_op_e                     op;
    logic [IDX_W-1:0]            set_idx;
    logic [TAG_W-1:0]            look_tag;
    logic [WAYS-1:0][TAG_W-1:0]  set_tags;
    logic [WAYS-1:0]             set_valid;
    logic [WAYS-1:0]             match_vec;
    logic [CNT_W-1:0]            match_cnt;
    logic [WAY_W-1:0]            low_way;
    logic [WAY_W-1:0]            victim;
    logic                        any_match;
    logic                        multi_match;
    logic                        is_fetch;
    logic                        is_touch;
    logic                        is_inval;
    logic                        forced;
    logic                        do_alloc;
    logic                        hit_now;
    logic                        multi_now;
    logic [WAY_W-1:0]            way_now;
    logic                        unused_bits;

    // Split the request into opcode, set index and tag fields.
    assign op       = icl_op_e'(req_op);
    assign set_idx  = req_addr[OFF_W +: IDX_W];
    assign look_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign unused_bits = ^{req_addr[OFF_W-1:0], match_cnt};

    assign is_fetch = req_valid && (op == OP_FETCH);
    assign is_touch = req_valid && (op == OP_TOUCH);
    assign is_inval = req_valid && (op == OP_INVAL);

    icl_tag_store #(
        .WAYS  (WAYS),
        .SETS  (SETS),
        .TAG_W (TAG_W),
        .IDX_W (IDX_W),
        .WAY_W (WAY_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_set    (set_idx),
        .rd_tags   (set_tags),
        .rd_valid  (set_valid),
        .alloc_en  (do_alloc),
        .alloc_set (set_idx),
        .alloc_way (victim),
        .alloc_tag (look_tag),
        .inv_en    (is_inval),
        .inv_set   (set_idx),
        .inv_mask  (match_vec)
    );

    icl_way_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .WAY_W (WAY_W),
        .CNT_W (CNT_W)
    ) u_match (
        .tags        (set_tags),
        .valid       (set_valid),
        .look_tag    (look_tag),
        .match_vec   (match_vec),
        .match_cnt   (match_cnt),
        .low_way     (low_way),
        .any_match   (any_match),
        .multi_match (multi_match)
    );

    icl_victim_rr #(
        .WAYS  (WAYS),
        .SETS  (SETS),
        .IDX_W (IDX_W),
        .WAY_W (WAY_W)
    ) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_set  (set_idx),
        .victim  (victim),
        .adv_en  (do_alloc),
        .adv_set (set_idx)
    );

    // Classify the lookup: allocate, hit, multi-hit, or nothing.
    always_comb begin
        forced    = is_touch && force_miss;
        do_alloc  = (is_fetch && !any_match) || (is_touch && (forced || !any_match));
        multi_now = is_fetch && multi_match;
        hit_now   = any_match && ((is_fetch && !multi_match) || (is_touch && !forced));
        if (do_alloc) begin
            way_now = victim;
        end else if (hit_now) begin
            way_now = low_way;
        end else begin
            way_now = '0;
        end
    end

    // Register the response so it appears one edge after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_miss      <= 1'b0;
            rsp_way       <= '0;
            rsp_multi_err <= 1'b0;
        end else begin
            rsp_valid     <= req_valid;
            rsp_hit       <= hit_now;
            rsp_miss      <= do_alloc;
            rsp_way       <= way_now;
            rsp_multi_err <= multi_now;
        end
    end

endmodule

// File: rtl/icl_tag_lookup_chk.sv
// Assertion checker for icl_tag_lookup, attached by bind below.
// Observes only the top-level ports; assumes a synchronous active-low reset.
module icl_tag_lookup_chk #(
    parameter int WAY_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_op,
    input logic             force_miss,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic [WAY_W-1:0] rsp_way,
    input logic             rsp_multi_err
);

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_no_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_flags_need_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_multi_err));

    assert_hit_miss_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_miss));

    assert_forced_touch_allocates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b01 && force_miss) |=> (rsp_miss && !rsp_hit));

    assert_multi_only_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 2'b00) |=> !rsp_multi_err);

    assert_multi_excludes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi_err |-> (!rsp_hit && !rsp_miss));

    assert_inval_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b10) |=> (!rsp_hit && !rsp_miss && !rsp_multi_err));

    assert_rsvd_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b11) |=> (!rsp_hit && !rsp_miss && !rsp_multi_err));

    assert_way_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_hit && !rsp_miss) |-> (rsp_way == '0));

endmodule

bind icl_tag_lookup icl_tag_lookup_chk #(.WAY_W(WAY_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_op        (req_op),
    .force_miss    (force_miss),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_miss      (rsp_miss),
    .rsp_way       (rsp_way),
    .rsp_multi_err (rsp_multi_err)
);

// File: tb/sim_icl_tag_lookup.sv
`timescale 1ns/1ps
module sim_icl_tag_lookup;

    localparam int WAYS = 4;
    localparam int SETS = 16;
    localparam int TAGW = 23;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_op;
    logic [31:0] req_addr;
    logic        force_miss;
    logic        rsp_valid;
    logic        rsp_hit;
    logic        rsp_miss;
    logic [1:0]  rsp_way;
    logic        rsp_multi_err;

    always #4 clk = ~clk;

    icl_tag_lookup u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .req_addr      (req_addr),
        .force_miss    (force_miss),
        .rsp_valid     (rsp_valid),
        .rsp_hit       (rsp_hit),
        .rsp_miss      (rsp_miss),
        .rsp_way       (rsp_way),
        .rsp_multi_err (rsp_multi_err)
    );

    typedef struct {
        logic [4:0] flags;   // {hit, miss, way[1:0], multi}
        string      rq;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    logic [TAGW-1:0] mtag [SETS][WAYS];
    bit              mval [SETS][WAYS];
    int              mrr  [SETS];

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Driver: model the requirement, queue the expected response, drive the request.
    task automatic issue(input logic [1:0] op, input logic [31:0] addr,
                         input bit fm, input string rq);
        exp_t e;
        int s;
        logic [TAGW-1:0] t;
        int cnt;
        int first;
        bit hit, miss, multi;
        int way;
        s = int'(addr[8:5]);
        t = addr[31:9];
        cnt = 0;
        first = -1;
        hit = 0; miss = 0; multi = 0; way = 0;
        for (int w = 0; w < WAYS; w++) begin
            if (mval[s][w] && mtag[s][w] == t) begin
                cnt++;
                if (first < 0) first = w;
            end
        end
        case (op)
            2'b00: begin
                if (cnt == 0) miss = 1;
                else if (cnt == 1) begin hit = 1; way = first; end
                else multi = 1;
            end
            2'b01: begin
                if (fm || cnt == 0) miss = 1;
                else begin hit = 1; way = first; end
            end
            2'b10: begin
                for (int w = 0; w < WAYS; w++)
                    if (mval[s][w] && mtag[s][w] == t) mval[s][w] = 0;
            end
            default: ;
        endcase
        if (miss) begin
            way = mrr[s];
            mtag[s][way] = t;
            mval[s][way] = 1;
            mrr[s] = (mrr[s] + 1) % WAYS;
        end
        e.flags = {hit, miss, 2'(way), multi};
        e.rq = rq;
        @(negedge clk);
        req_valid  = 1'b1;
        req_op     = op;
        req_addr   = addr;
        force_miss = fm;
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid  = 1'b0;
        force_miss = 1'b0;
        req_op     = 2'b00;
    endtask

    function automatic logic [31:0] mk(input int tag, input int set);
        return {23'(tag), 4'(set), 5'h0};
    endfunction

    // Monitor: compare each response with the head of the expectation queue.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            if (rsp_valid) begin
                if (q.size() == 0) begin
                    check(0, "R2", "unexpected response", 32'(rsp_valid), 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check({rsp_hit, rsp_miss, rsp_way, rsp_multi_err} === e.flags, e.rq,
                          "{hit,miss,way,multi}",
                          32'({rsp_hit, rsp_miss, rsp_way, rsp_multi_err}), 32'(e.flags));
                end
            end else begin
                check(!(rsp_hit || rsp_miss || rsp_multi_err), "R2", "flags while idle",
                      32'({rsp_hit, rsp_miss, rsp_multi_err}), 0);
            end
        end
    end

    initial begin
        for (int s = 0; s < SETS; s++) begin
            mrr[s] = 0;
            for (int w = 0; w < WAYS; w++) begin
                mval[s][w] = 0;
                mtag[s][w] = '0;
            end
        end
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_op = 2'b00;
        req_addr = '0;
        force_miss = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 32'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);

        issue(2'b00, mk(5, 0) | 32'h1c, 0, "R1");   // first fetch misses, way 0
        issue(2'b00, mk(5, 0), 0, "R3");            // same line hits way 0
        issue(2'b00, mk(9, 0), 0, "R4");            // same set, next way 1
        issue(2'b00, mk(5, 3), 0, "R4");            // other set starts at way 0
        idle();
        issue(2'b01, mk(5, 0), 0, "R5");            // touch hit, no allocation
        issue(2'b00, mk(5, 0), 1, "R8");            // force ignored on fetch
        issue(2'b01, mk(5, 0), 1, "R6");            // forced touch duplicates into way 2
        issue(2'b00, mk(5, 0), 0, "R7");            // fetch sees two copies
        issue(2'b00, mk(12, 0), 0, "R7");           // pointer not moved: way 3
        issue(2'b01, mk(5, 0), 0, "R10");           // touch on duplicates: lowest way
        issue(2'b10, mk(5, 0), 0, "R9");            // invalidate both copies
        issue(2'b00, mk(5, 0), 0, "R9");            // now misses, refills way 0
        issue(2'b00, mk(9, 0), 0, "R9");            // other line kept, hits way 1
        issue(2'b11, mk(9, 0), 0, "R11");           // reserved op: all zero
        issue(2'b00, mk(9, 0), 0, "R11");           // reserved op left state alone
        idle();
        for (int i = 0; i < 48; i++) begin
            issue(2'b00, mk(100 + (i % 6), i % 16), (i % 3) == 0, "R4");
        end
        for (int i = 0; i < 8; i++) begin
            issue(2'b01, mk(100 + (i % 6), i % 16), 1, "R6");
        end
        for (int i = 0; i < 8; i++) begin
            issue(2'b00, mk(100 + (i % 6), i % 16), 0, "R7");
        end
        idle();
        repeat (3) idle();
        check(q.size() == 0, "R2", "responses outstanding", 32'(q.size()), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog expired actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule